// File: doc/BRIEF.md
# Weighted Exposure Metering Engine

This block watches a stream of 8-bit luminance pixels and produces one exposure figure per image. The active picture is cut into an 8 by 8 grid of equal areas, and each area is averaged. Two views of the grid are formed. The first is a row-weighted mean, in which every grid row has its own programmable weight. The second is the plain mean of a rectangular window of areas. A programmable window weight blends the two.

Alongside the grid, the block keeps the brightest and the darkest short horizontal average seen in the image. Each short average covers 4 or 8 neighbouring pixels. Both levels are mixed into the blended figure by two 8-bit factors. The result is registered and announced by a single-cycle strobe once the last active line has ended. A shutter or gain loop downstream reads it there.

Top module: `exposure_meter`

## Requirements
- R1: The frame is split into 8x8 areas, each (ACT_W/8) pixels wide and (ACT_H/8) lines high. Each area average is the floor of its pixel sum divided by its pixel count. Row 0 is the first line group and column 0 is the first pixel group.
- R2: Row-weighted value W1 = floor(sum over rows r of floor(S_r/8) * wgt_r / 256), saturated at 255. S_r is the sum of the 8 area averages in row r, and wgt_r is `row_wt[8r+7:8r]`.
- R3: Window value W2 is the floor of the mean of the area averages with row in [tl>>3, br>>3] and column in [tl&7, br&7]. Here tl is `win_tl`, br is `win_br`, and an area code is row*8+column. If the bottom row is above the top row, or the right column is left of the left column, the window is empty and W2 = 0.
- R4: Blend B = floor((W1*(64-cw) + W2*cw)/64), with cw = `win_wt`. A `win_wt` above 64 acts as 64.
- R5: Top level is the maximum, and bottom level the minimum, over the frame of floor(group sum / G). Groups are consecutive runs of G pixels aligned to the start of each line, with G = 4 when `short_avg4` = 1 and G = 8 when it is 0. Incomplete groups are discarded. With no complete group, top is 0 and bottom is 255.
- R6: Result = floor((B*(256-k_top-k_bot) + top*k_top + bot*k_bot)/256), saturated at 255. When k_top + k_bot is 256 or more, the B term is zero.
- R7: `exp_valid` is high for exactly one cycle. It starts at the second rising edge after the edge that first samples `line_valid` low at the end of active line ACT_H of the frame. `exp_value` changes only at that edge.
- R8: `frame_start` clears the area accumulators, line and pixel position, and the top and bottom trackers. A frame's result does not depend on any earlier, even unfinished, frame.
- R9: While `rst_n` is low at a clock edge, the following cycle has `exp_value` = 0 and `exp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse before the first line of a frame |
| line_valid | input | 1 | High throughout an active line |
| pix_valid | input | 1 | Pixel present on `pix_y` this cycle |
| pix_y | input | 8 | Luminance sample |
| row_wt | input | 64 | Eight 8-bit grid-row weights, row r at bits 8r+7:8r |
| win_tl | input | 6 | Window top-left area code (row*8+column) |
| win_br | input | 6 | Window bottom-right area code (row*8+column) |
| win_wt | input | 7 | Window weight cw |
| short_avg4 | input | 1 | 1: 4-pixel groups, 0: 8-pixel groups |
| k_top | input | 8 | Top-level mixing factor |
| k_bot | input | 8 | Bottom-level mixing factor |
| exp_value | output | 8 | Exposure figure of the last complete frame |
| exp_valid | output | 1 | One-cycle strobe for a new `exp_value` |

## Verification
The result of a frame is due two rising edges after the edge that sees `line_valid` fall at the end of the last active line. The first edge folds the last area row into the sums, and the second registers the mixed figure. The bench drives inputs on falling edges and samples on falling edges. It checks the strobe low one half-cycle after the first edge, high with the expected figure after the second edge, and low again with the figure held after the third. Expected figures come from an arithmetic model of the requirements applied to the same image. The runs sweep window shapes, row weights, group widths and mixing factors, and include an aborted frame.

// File: rtl/exp_meter_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and helpers for the exposure metering engine.
package exp_meter_pkg;
    localparam int GRID   = 8;   // areas per grid row and per grid column
    localparam int PIX_W  = 8;   // luminance width
    localparam int WSUM_W = 19;  // row-weighted accumulator width
    localparam int WIN_W  = 14;  // window accumulator width (64 areas x 255)

    typedef logic [PIX_W-1:0] pix_t;

    // Clamp an 11-bit intermediate to the 8-bit luminance range.
    function automatic pix_t sat_pix(input logic [10:0] val);
        return (val > 11'd255) ? 8'hFF : val[7:0];
    endfunction
endpackage

// File: rtl/exp_area_accum.sv
`timescale 1ns/1ps
// Area accumulator: sums the pixels of the eight areas in the current grid
// row, turns them into averages when the grid row ends, and folds them into
// the row-weighted sum and the window sum.
// Assumes: col/row are already limited to the active grid; row_end is a
// single-cycle pulse with no pixel in the same cycle.
module exp_area_accum
    import exp_meter_pkg::*;
#(
    parameter int AREA_PIX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pix_en,
    input  logic [2:0]        col,
    input  pix_t              pix,
    input  logic              row_end,
    input  logic [2:0]        row,
    input  logic [63:0]       row_wt,
    input  logic [5:0]        win_tl,
    input  logic [5:0]        win_br,
    output logic [WSUM_W-1:0] wsum,
    output logic [WIN_W-1:0]  win_sum
);
    localparam int ACC_W = PIX_W + $clog2(AREA_PIX) + 1;

    pix_t         avg [GRID];
    logic [GRID-1:0] in_win;
    logic         row_hit;
    logic [10:0]  row_sum;
    logic [10:0]  win_row;
    logic [7:0]   wt_sel;
    logic [15:0]  prod;

    assign row_hit = (row >= win_tl[5:3]) && (row <= win_br[5:3]);

    generate
        for (genvar c = 0; c < GRID; c++) begin : g_col
            logic [ACC_W-1:0] acc;

            // Accumulate the pixels falling into this column's area.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc <= '0;
                end else if (clr || row_end) begin
                    acc <= '0;
                end else if (pix_en && (col == 3'(c))) begin
                    acc <= acc + ACC_W'(pix);
                end
            end

            assign avg[c]    = pix_t'(acc / ACC_W'(AREA_PIX));
            assign in_win[c] = row_hit && (3'(c) >= win_tl[2:0]) && (3'(c) <= win_br[2:0]);
        end
    endgenerate

    // Add up the area averages of this grid row, overall and inside the window.
    always_comb begin
        row_sum = '0;
        win_row = '0;
        for (int c = 0; c < GRID; c++) begin
            row_sum = row_sum + 11'(avg[c]);
            if (in_win[c]) begin
                win_row = win_row + 11'(avg[c]);
            end
        end
    end

    assign wt_sel = row_wt[{row, 3'b000} +: 8];
    assign prod   = 16'(8'(row_sum >> 3)) * 16'(wt_sel);

    // Fold a finished grid row into the frame-level sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsum    <= '0;
            win_sum <= '0;
        end else if (clr) begin
            wsum    <= '0;
            win_sum <= '0;
        end else if (row_end) begin
            wsum    <= wsum + WSUM_W'(prod);
            win_sum <= win_sum + WIN_W'(win_row);
        end
    end
endmodule

// File: rtl/exp_peak_track.sv
`timescale 1ns/1ps
// Peak tracker: averages runs of 4 or 8 consecutive pixels, aligned to the
// line start, and keeps the largest and smallest run average of the frame.
// Assumes: short_avg4 is steady within a line; partial runs at line end drop.
module exp_peak_track
    import exp_meter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic line_end,
    input  logic pix_en,
    input  logic short_avg4,
    input  pix_t pix,
    output pix_t top_lvl,
    output pix_t bot_lvl
);
    logic [2:0]  gcnt;
    logic [10:0] gsum;
    logic [10:0] tot;
    logic        last;
    pix_t        gavg;

    assign tot  = gsum + 11'(pix);
    assign last = short_avg4 ? (gcnt == 3'd3) : (gcnt == 3'd7);
    assign gavg = short_avg4 ? pix_t'(tot >> 2) : pix_t'(tot >> 3);

    // Build run sums and update the extremes when a run completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt    <= '0;
            gsum    <= '0;
            top_lvl <= '0;
            bot_lvl <= 8'hFF;
        end else if (clr) begin
            gcnt    <= '0;
            gsum    <= '0;
            top_lvl <= '0;
            bot_lvl <= 8'hFF;
        end else if (line_end) begin
            gcnt <= '0;
            gsum <= '0;
        end else if (pix_en) begin
            if (last) begin
                gcnt <= '0;
                gsum <= '0;
                if (gavg > top_lvl) top_lvl <= gavg;
                if (gavg < bot_lvl) bot_lvl <= gavg;
            end else begin
                gcnt <= gcnt + 3'd1;
                gsum <= tot;
            end
        end
    end
endmodule

// File: rtl/exp_blend.sv
`timescale 1ns/1ps
// Blend stage (combinational): derives the row-weighted and window means,
// blends them by the window weight, then mixes in the top and bottom levels.
// Assumes: inputs are stable for the cycle in which the result is registered.
module exp_blend
    import exp_meter_pkg::*;
(
    input  logic [WSUM_W-1:0] wsum,
    input  logic [WIN_W-1:0]  win_sum,
    input  logic [5:0]        win_tl,
    input  logic [5:0]        win_br,
    input  logic [6:0]        win_wt,
    input  pix_t              k_top,
    input  pix_t              k_bot,
    input  pix_t              top_lvl,
    input  pix_t              bot_lvl,
    output pix_t              value
);
    logic [10:0] w1_raw;
    pix_t        w1;
    pix_t        w2;
    logic [3:0]  rspan;
    logic [3:0]  cspan;
    logic [6:0]  cnt;
    logic [6:0]  cwc;
    logic [15:0] mix;
    pix_t        blend;
    logic [8:0]  ksum;
    logic [8:0]  kres;
    logic [18:0] fin;

    // Row-weighted mean, saturated.
    assign w1_raw = 11'(wsum >> 8);
    assign w1     = sat_pix(w1_raw);

    // Window size in areas; an inverted corner pair gives an empty window.
    assign rspan = (win_br[5:3] >= win_tl[5:3]) ? (4'(win_br[5:3] - win_tl[5:3]) + 4'd1) : 4'd0;
    assign cspan = (win_br[2:0] >= win_tl[2:0]) ? (4'(win_br[2:0] - win_tl[2:0]) + 4'd1) : 4'd0;
    assign cnt   = 7'(8'(rspan) * 8'(cspan));
    assign w2    = (cnt == 7'd0) ? 8'd0 : pix_t'(win_sum / WIN_W'(cnt));

    // Window weight blend with the weight clamped to 64.
    assign cwc   = (win_wt > 7'd64) ? 7'd64 : win_wt;
    assign mix   = 16'(w1) * 16'(7'd64 - cwc) + 16'(w2) * 16'(cwc);
    assign blend = pix_t'(mix >> 6);

    // Peak mixing; the blended share vanishes when the factors reach 256.
    assign ksum  = 9'(k_top) + 9'(k_bot);
    assign kres  = (ksum >= 9'd256) ? 9'd0 : (9'd256 - ksum);
    assign fin   = 19'(blend) * 19'(kres) + 19'(top_lvl) * 19'(k_top) + 19'(bot_lvl) * 19'(k_bot);
    assign value = sat_pix(11'(fin >> 8));
endmodule

// File: rtl/exposure_meter.sv
`timescale 1ns/1ps
// Exposure metering engine top: tracks the pixel position within the 8x8
// grid, feeds the area accumulator and the peak tracker, and registers the
// blended exposure figure one cycle after the last grid row is folded in.
// Assumes: ACT_W and ACT_H are multiples of 8; frame_start arrives while
// line_valid is low; pixels beyond the active area do not enter the grid.
module exposure_meter
    import exp_meter_pkg::*;
#(
    parameter int ACT_W = 32,
    parameter int ACT_H = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        line_valid,
    input  logic        pix_valid,
    input  logic [7:0]  pix_y,
    input  logic [63:0] row_wt,
    input  logic [5:0]  win_tl,
    input  logic [5:0]  win_br,
    input  logic [6:0]  win_wt,
    input  logic        short_avg4,
    input  logic [7:0]  k_top,
    input  logic [7:0]  k_bot,
    output logic [7:0]  exp_value,
    output logic        exp_valid
);
    localparam int AREA_W   = ACT_W / GRID;
    localparam int AREA_H   = ACT_H / GRID;
    localparam int AREA_PIX = AREA_W * AREA_H;
    localparam int XW       = (AREA_W > 1) ? $clog2(AREA_W) : 1;
    localparam int YW       = (AREA_H > 1) ? $clog2(AREA_H) : 1;

    logic              lv_q;
    logic [XW-1:0]     x_sub;
    logic [3:0]        col;
    logic [YW-1:0]     y_sub;
    logic [3:0]        row;
    logic              line_end;
    logic              pix_en;
    logic              area_en;
    logic              row_end;
    logic              frame_end;
    logic              eof_q;
    logic [WSUM_W-1:0] wsum;
    logic [WIN_W-1:0]  win_sum;
    pix_t              top_lvl;
    pix_t              bot_lvl;
    pix_t              value;

    assign line_end  = lv_q & ~line_valid;
    assign pix_en    = line_valid & pix_valid;
    assign area_en   = pix_en & ~col[3] & ~row[3];
    assign row_end   = line_end & (y_sub == YW'(AREA_H - 1)) & ~row[3];
    assign frame_end = row_end & (row == 4'd7);

    // Remember line_valid to find the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= 1'b0;
        else        lv_q <= line_valid;
    end

    // Horizontal and vertical position inside the area grid.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            x_sub <= '0;
            col   <= '0;
            y_sub <= '0;
            row   <= '0;
        end else begin
            if (pix_en && !col[3]) begin
                if (x_sub == XW'(AREA_W - 1)) begin
                    x_sub <= '0;
                    col   <= col + 4'd1;
                end else begin
                    x_sub <= x_sub + XW'(1);
                end
            end
            if (line_end) begin
                x_sub <= '0;
                col   <= '0;
                if (!row[3]) begin
                    if (y_sub == YW'(AREA_H - 1)) begin
                        y_sub <= '0;
                        row   <= row + 4'd1;
                    end else begin
                        y_sub <= y_sub + YW'(1);
                    end
                end
            end
        end
    end

    exp_area_accum #(
        .AREA_PIX (AREA_PIX)
    ) i_area (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (frame_start),
        .pix_en  (area_en),
        .col     (col[2:0]),
        .pix     (pix_y),
        .row_end (row_end),
        .row     (row[2:0]),
        .row_wt  (row_wt),
        .win_tl  (win_tl),
        .win_br  (win_br),
        .wsum    (wsum),
        .win_sum (win_sum)
    );

    exp_peak_track i_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (frame_start),
        .line_end   (line_end),
        .pix_en     (pix_en),
        .short_avg4 (short_avg4),
        .pix        (pix_y),
        .top_lvl    (top_lvl),
        .bot_lvl    (bot_lvl)
    );

    exp_blend i_blend (
        .wsum    (wsum),
        .win_sum (win_sum),
        .win_tl  (win_tl),
        .win_br  (win_br),
        .win_wt  (win_wt),
        .k_top   (k_top),
        .k_bot   (k_bot),
        .top_lvl (top_lvl),
        .bot_lvl (bot_lvl),
        .value   (value)
    );

    // Delay the frame end by one cycle so the last grid row is in the sums.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) eof_q <= 1'b0;
        else                       eof_q <= frame_end;
    end

    // Register the exposure figure and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_value <= '0;
            exp_valid <= 1'b0;
        end else begin
            exp_valid <= eof_q;
            if (eof_q) exp_value <= value;
        end
    end
endmodule

// File: rtl/exp_meter_chk.sv
`timescale 1ns/1ps
// Checker for the exposure metering engine: strobe shape and timing, output
// hold, tracker direction within a frame, frame clearing and reset state.
module exp_meter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       line_valid,
    input logic       exp_valid,
    input logic [7:0] exp_value,
    input logic [7:0] top_lvl,
    input logic [7:0] bot_lvl
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exp_valid |=> !exp_valid); // R7

    AST_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        exp_valid |-> (!$past(line_valid, 2) && $past(line_valid, 3))); // R7

    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exp_value) |-> exp_valid); // R7

    AST_TOP_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> (top_lvl >= $past(top_lvl))); // R5

    AST_BOT_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> (bot_lvl <= $past(bot_lvl))); // R5

    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> (top_lvl == 8'd0 && bot_lvl == 8'hFF)); // R8

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (exp_value == 8'd0 && !exp_valid)); // R9
endmodule

bind exposure_meter exp_meter_chk i_exp_meter_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_valid  (line_valid),
    .exp_valid   (exp_valid),
    .exp_value   (exp_value),
    .top_lvl     (top_lvl),
    .bot_lvl     (bot_lvl)
);

// File: tb/test_exposure_meter.sv
`timescale 1ns/1ps
module test_exposure_meter;
    localparam int W  = 32;
    localparam int H  = 16;
    localparam int AW = W / 8;
    localparam int AH = H / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_valid = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_y = 8'd0;
    logic [63:0] rw = {8{8'd32}};
    logic [5:0]  wtl = 6'd0;
    logic [5:0]  wbr = 6'd63;
    logic [6:0]  cw = 7'd32;
    logic        s4 = 1'b0;
    logic [7:0]  kt = 8'd0;
    logic [7:0]  kb = 8'd0;
    logic [7:0]  exp_value;
    logic        exp_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int img [H][W];

    always #2.5 clk = ~clk;

    exposure_meter #(.ACT_W(W), .ACT_H(H)) i_exposure_meter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_valid(line_valid), .pix_valid(pix_valid), .pix_y(pix_y),
        .row_wt(rw), .win_tl(wtl), .win_br(wbr), .win_wt(cw),
        .short_avg4(s4), .k_top(kt), .k_bot(kb),
        .exp_value(exp_value), .exp_valid(exp_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int pix_of(input int pat, input int seed, input int y, input int x);
        case (pat)
            0: return seed & 255;
            1: return (x * 8 + y * 4) & 255;
            2: return (x * 37 + y * 91 + seed * 53 + x * y * 13 + (x ^ y) * 7) % 256;
            3: return (y == 5 && x >= 8 && x < 12) ? 255 : 20;
            default: return (y == 9 && x >= 16 && x < 20) ? 0 : 200;
        endcase
    endfunction

    task automatic fill(input int pat, input int seed);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = pix_of(pat, seed, y, x);
    endtask

    // Arithmetic model of R1..R6.
    function automatic int model();
        int a [8][8];
        int w1, w2, sum, cnt, rs, tr, tc, brr, bcc, cwc, blend, g, top, bot, ks, kr, fin, avg;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                sum = 0;
                for (int dy = 0; dy < AH; dy++)
                    for (int dx = 0; dx < AW; dx++)
                        sum += img[r * AH + dy][c * AW + dx];
                a[r][c] = sum / (AW * AH);
            end
        w1 = 0;
        for (int r = 0; r < 8; r++) begin
            rs = 0;
            for (int c = 0; c < 8; c++) rs += a[r][c];
            w1 += (rs / 8) * int'(rw[r * 8 +: 8]);
        end
        w1 = w1 / 256;
        if (w1 > 255) w1 = 255;
        tr = int'(wtl) / 8; tc = int'(wtl) % 8; brr = int'(wbr) / 8; bcc = int'(wbr) % 8;
        sum = 0; cnt = 0;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if (r >= tr && r <= brr && c >= tc && c <= bcc) begin
                    sum += a[r][c]; cnt++;
                end
        w2 = (cnt == 0) ? 0 : sum / cnt;
        cwc = (int'(cw) > 64) ? 64 : int'(cw);
        blend = (w1 * (64 - cwc) + w2 * cwc) / 64;
        g = s4 ? 4 : 8;
        top = 0; bot = 255;
        for (int y = 0; y < H; y++)
            for (int k = 0; k < W / g; k++) begin
                sum = 0;
                for (int j = 0; j < g; j++) sum += img[y][k * g + j];
                avg = sum / g;
                if (avg > top) top = avg;
                if (avg < bot) bot = avg;
            end
        ks = int'(kt) + int'(kb);
        kr = (ks >= 256) ? 0 : 256 - ks;
        fin = (blend * kr + top * int'(kt) + bot * int'(kb)) / 256;
        return (fin > 255) ? 255 : fin;
    endfunction

    task automatic drive_frame(input int lines);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int y = 0; y < lines; y++) begin
            for (int x = 0; x < W; x++) begin
                @(negedge clk);
                line_valid = 1'b1; pix_valid = 1'b1; pix_y = 8'(img[y][x]);
            end
            @(negedge clk);
            line_valid = 1'b0; pix_valid = 1'b0; pix_y = 8'd0;
            if (y != lines - 1) @(negedge clk);
        end
    endtask

    // One full frame and the checks on its result (R7 timing plus req value).
    task automatic run(input int pat, input int seed, input string req);
        int expv;
        fill(pat, seed);
        expv = model();
        drive_frame(H);
        @(negedge clk);
        chk(exp_valid == 1'b0, "R7 strobe early", int'(exp_valid), 0);
        @(negedge clk);
        chk(exp_valid == 1'b1, "R7 strobe due", int'(exp_valid), 1);
        chk(int'(exp_value) == expv, req, int'(exp_value), expv);
        @(negedge clk);
        chk(exp_valid == 1'b0, "R7 strobe width", int'(exp_valid), 0);
        chk(int'(exp_value) == expv, "R7 value hold", int'(exp_value), expv);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(exp_value == 8'd0, "R9 reset value", int'(exp_value), 0);
        chk(exp_valid == 1'b0, "R9 reset strobe", int'(exp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(exp_valid == 1'b0, "R9 after release", int'(exp_valid), 0);

        // R1: flat and textured images with uniform row weights
        run(0, 100, "R1 flat");
        run(2, 1, "R1 textured");
        // R2: row weights
        rw = {8'd0, 8'd0, 8'd64, 8'd64, 8'd64, 8'd64, 8'd0, 8'd0}; cw = 7'd0;
        run(1, 0, "R2 centre rows");
        rw = {8'd16, 8'd16, 8'd16, 8'd16, 8'd48, 8'd48, 8'd48, 8'd48};
        run(2, 7, "R2 upper rows");
        // R3: window shapes
        rw = {8{8'd32}}; cw = 7'd64;
        wtl = 6'd27; wbr = 6'd27; run(2, 3, "R3 single area");
        wtl = 6'd9;  wbr = 6'd54; run(1, 0, "R3 rectangle");
        wtl = 6'd54; wbr = 6'd9;  run(2, 4, "R3 empty window");
        // R4: blend weight, including clamp above 64
        wtl = 6'd9; wbr = 6'd54;
        cw = 7'd100; run(2, 5, "R4 clamp");
        cw = 7'd20;  run(2, 6, "R4 mix 20");
        cw = 7'd48;  run(1, 0, "R4 mix 48");
        // R5: top and bottom with both group widths
        wtl = 6'd0; wbr = 6'd63; cw = 7'd32;
        kt = 8'd128; kb = 8'd0;
        s4 = 1'b0; run(3, 0, "R5 top 8px");
        s4 = 1'b1; run(3, 0, "R5 top 4px");
        kt = 8'd0; kb = 8'd128;
        run(4, 0, "R5 bottom 4px");
        s4 = 1'b0; run(4, 0, "R5 bottom 8px");
        // R6: mixing factors
        kt = 8'd40;  kb = 8'd60; run(2, 8, "R6 general");
        kt = 8'd200; kb = 8'd100; run(2, 9, "R6 over 256");
        kt = 8'd255; kb = 8'd1;   run(3, 0, "R6 sum 256");
        // R8: unfinished frames must leave no trace
        kt = 8'd128; kb = 8'd0;
        fill(0, 255); drive_frame(5);
        run(0, 50, "R8 top cleared");
        kt = 8'd0; kb = 8'd128;
        fill(0, 0); drive_frame(11);
        run(0, 50, "R8 bottom cleared");
        // R3: sweep of window corners and group widths
        kt = 8'd30; kb = 8'd30;
        for (int i = 0; i < 8; i++) begin
            wtl = 6'(i * 9); wbr = 6'(63 - i * 8); s4 = i[0];
            cw = 7'(64 - i * 4);
            run(2, 20 + i, "R3 sweep");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule